// File: doc/BRIEF.md
# Nibble-Coded Register Access Port

This block sits on the device side of a byte-wide host link. It turns the bytes it receives into reads and writes on a small register bank. Every incoming byte has two halves. The upper half is an opcode and the lower half is a 4-bit payload. A register address is assembled from two nibble commands. Write data is assembled the same way, and a write is committed only by the command that carries the upper data nibble. A read command returns one byte on a valid/ready response stream. A variant of the read command also steps the address, so a run of reads walks through consecutive registers, for example two 24-bit counters read least significant byte first.

The port holds two registers of its own: a constant identity register and a scratch register. The host uses these to check the link. Every other address is passed to an external register bank through a combinational read-data input, a write strobe and a read strobe.

Top module: `nib_reg_port`

## Requirements
- R1: Opcode 0x0 in bits [7:4] loads the payload into address bits [3:0] and leaves bits [7:4] unchanged.
- R2: Opcode 0x1 loads the payload into address bits [7:4] and leaves bits [3:0] unchanged.
- R3: Opcode 0x2 latches the payload as the low data nibble and raises no write or read strobe.
- R4: Opcode 0x3 raises `reg_we_o` for exactly the cycle in which its byte is accepted. In that cycle the write data is {payload, latched low nibble} and the address is the current address.
- R5: Repeated 0x2/0x3 pairs after a single address all write to that same address, and the last value written is the one read back.
- R6: Opcode 0x4 returns the byte stored at the current address on the response stream and leaves the address unchanged.
- R7: Opcode 0x5 returns the byte at the current address and then adds one to the address, wrapping from 0xFF to 0x00. Six such reads return six consecutive registers in address order.
- R8: The address given by `ID_ADDR` (default 0x00) always reads 0xA6, and writes to it have no effect.
- R9: The address given by `SCRATCH_ADDR` (default 0x01) reads back the last byte written to it, including 0x55 and 0xAA.
- R10: While a response byte is waiting, `cmd_ready_o` is low. The response data stays stable and no command is consumed until the byte is accepted.
- R11: Opcodes 0x6 to 0xF are consumed without effect. They raise no strobe and no response, and they leave the address and the low data nibble unchanged.
- R12: After reset the address is 0x00, the low data nibble is 0x0, no response is pending and `cmd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte present |
| cmd_data_i | input | 8 | Command byte: opcode [7:4], payload [3:0] |
| cmd_ready_o | output | 1 | Command byte can be consumed |
| rsp_valid_o | output | 1 | Response byte present |
| rsp_data_o | output | 8 | Response byte |
| rsp_ready_i | input | 1 | Response byte taken |
| reg_addr_o | output | 8 | Current register address |
| reg_wdata_o | output | 8 | Write data, valid while reg_we_o is high |
| reg_we_o | output | 1 | Write strobe |
| reg_re_o | output | 1 | Read strobe |
| reg_rdata_i | input | 8 | Combinational read data from the external bank |

## Verification
The main function is exercised with four groups of command streams:
- The identity/scratch link check, which separates the constant register from the writable one and from the external bank.
- Several data pairs sent to one address, which shows whether the address survives a commit and whether the last write wins.
- A run of six incrementing reads over counter bytes, followed by an increment from 0xFF, which separates stepping from non-stepping reads and exposes a missing wrap.
- Reserved opcodes placed between a low nibble and its commit, which reveals any side effect on the address or on the latched nibble.

A response held back for several cycles, with a command waiting at the input, shows whether intake really stalls.

// File: rtl/nib_pkg.sv
`timescale 1ns/1ps
package nib_pkg;
  typedef enum logic [3:0] {
    OP_ADDR_LO  = 4'h0,
    OP_ADDR_HI  = 4'h1,
    OP_DATA_LO  = 4'h2,
    OP_DATA_WR  = 4'h3,
    OP_READ     = 4'h4,
    OP_READ_INC = 4'h5
  } nib_op_e;

  typedef struct packed {
    logic ld_alo;
    logic ld_ahi;
    logic ld_dlo;
    logic commit;
    logic rd;
    logic inc;
  } nib_act_t;
endpackage

// File: rtl/nib_cmd_decode.sv
`timescale 1ns/1ps
module nib_cmd_decode
  import nib_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               fire_i,
  input  logic [2*NIB_W-1:0] byte_i,
  output nib_act_t           act_o,
  output logic [NIB_W-1:0]   nib_o
);
  logic [NIB_W-1:0] op;
  assign op    = byte_i[2*NIB_W-1:NIB_W];
  assign nib_o = byte_i[NIB_W-1:0];

  always_comb begin
    act_o = '0;
    if (fire_i) begin
      case (op)
        NIB_W'(OP_ADDR_LO):  act_o.ld_alo = 1'b1;
        NIB_W'(OP_ADDR_HI):  act_o.ld_ahi = 1'b1;
        NIB_W'(OP_DATA_LO):  act_o.ld_dlo = 1'b1;
        NIB_W'(OP_DATA_WR):  act_o.commit = 1'b1;
        NIB_W'(OP_READ):     act_o.rd     = 1'b1;
        NIB_W'(OP_READ_INC): begin act_o.rd = 1'b1; act_o.inc = 1'b1; end
        default: ;  // reserved opcodes consumed silently
      endcase
    end
  end
endmodule

// File: rtl/nib_addr_data.sv
`timescale 1ns/1ps
module nib_addr_data
  import nib_pkg::*;
#(
  parameter int NIB_W  = 4,
  localparam int ADDR_W = 2*NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  nib_act_t          act_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NIB_W-1:0]  dlo_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [NIB_W-1:0]  dlo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (act_i.ld_alo) begin
      addr_q[NIB_W-1:0] <= nib_i;
    end else if (act_i.ld_ahi) begin
      addr_q[ADDR_W-1:NIB_W] <= nib_i;
    end else if (act_i.inc) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           dlo_q <= '0;
    else if (act_i.ld_dlo) dlo_q <= nib_i;
  end

  assign addr_o = addr_q;
  assign dlo_o  = dlo_q;

  assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.commit |=> addr_q == $past(addr_q));
  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.inc |=> addr_q == $past(addr_q) + ADDR_W'(1));
  assert_lo_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.ld_alo |=> addr_q[ADDR_W-1:NIB_W] == $past(addr_q[ADDR_W-1:NIB_W]));
  assert_dlo_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i.ld_dlo |=> $stable(dlo_q));
endmodule

// File: rtl/nib_local_regs.sv
`timescale 1ns/1ps
module nib_local_regs #(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 8,
  parameter logic [7:0]  ID_ADDR      = 8'h00,
  parameter logic [7:0]  SCRATCH_ADDR = 8'h01,
  parameter logic [7:0]  ID_VALUE     = 8'hA6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] scratch_q;
  logic hit_id, hit_scr;

  assign hit_id  = addr_i == ADDR_W'(ID_ADDR);
  assign hit_scr = addr_i == ADDR_W'(SCRATCH_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               scratch_q <= '0;
    else if (we_i && hit_scr)  scratch_q <= wdata_i;
  end

  always_comb begin
    if (hit_id)       rdata_o = DATA_W'(ID_VALUE);
    else if (hit_scr) rdata_o = scratch_q;
    else              rdata_o = ext_rdata_i;
  end

  assert_scratch_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_scr) |=> scratch_q == $past(wdata_i));
endmodule

// File: rtl/nib_rsp_slot.sv
`timescale 1ns/1ps
module nib_rsp_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ready_i
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  assert_rsp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> valid_q && $stable(data_q));
  assert_no_overrun_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_q);
endmodule

// File: rtl/nib_reg_port.sv
`timescale 1ns/1ps
module nib_reg_port
  import nib_pkg::*;
#(
  parameter int          NIB_W        = 4,
  parameter logic [7:0]  ID_ADDR      = 8'h00,
  parameter logic [7:0]  SCRATCH_ADDR = 8'h01,
  parameter logic [7:0]  ID_VALUE     = 8'hA6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_data_i,
  output logic       cmd_ready_o,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  input  logic       rsp_ready_i,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  output logic       reg_re_o,
  input  logic [7:0] reg_rdata_i
);
  localparam int W = 2*NIB_W;

  nib_act_t         act;
  logic [NIB_W-1:0] nib, dlo;
  logic [W-1:0]     addr, rd_mux;
  logic             fire;

  assign cmd_ready_o = !rsp_valid_o;
  assign fire        = cmd_valid_i && cmd_ready_o;

  nib_cmd_decode #(.NIB_W(NIB_W)) u_dec (
    .fire_i(fire), .byte_i(cmd_data_i), .act_o(act), .nib_o(nib)
  );

  nib_addr_data #(.NIB_W(NIB_W)) u_ad (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .nib_i(nib),
    .addr_o(addr), .dlo_o(dlo)
  );

  nib_local_regs #(
    .ADDR_W(W), .DATA_W(W), .ID_ADDR(ID_ADDR),
    .SCRATCH_ADDR(SCRATCH_ADDR), .ID_VALUE(ID_VALUE)
  ) u_loc (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(reg_wdata_o),
    .we_i(reg_we_o), .ext_rdata_i(reg_rdata_i), .rdata_o(rd_mux)
  );

  nib_rsp_slot #(.DATA_W(W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act.rd), .data_i(rd_mux),
    .valid_o(rsp_valid_o), .data_o(rsp_data_o), .ready_i(rsp_ready_i)
  );

  assign reg_addr_o  = addr;
  assign reg_wdata_o = {nib, dlo};
  assign reg_we_o    = act.commit;
  assign reg_re_o    = act.rd;

  assert_one_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o}));
  assert_stall_intake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !reg_we_o && !reg_re_o);
  assert_read_answers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> rsp_valid_o);
  assert_id_const_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_o && reg_addr_o == ID_ADDR) |=> rsp_data_o == ID_VALUE);
endmodule

// File: tb/nib_reg_port_test.sv
`timescale 1ns/1ps
module nib_reg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ready, rsp_valid, rsp_ready, we, re;
  logic [7:0] rsp_data, addr, wdata, rdata;
  logic [7:0] mem [256];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic cap_we, cap_re;
  logic [7:0] cap_wdata, cap_addr, got;

  always #2 clk = ~clk;

  nib_reg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data),
    .cmd_ready_o(cmd_ready), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rsp_ready_i(rsp_ready), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  // external register bank model
  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;

  // {cmd, expects response, expected byte}
  localparam int NV = 35;
  localparam logic [16:0] VEC [NV] = '{
    {8'h00,1'b0,8'h00}, {8'h10,1'b0,8'h00}, {8'h40,1'b1,8'hA6},            // R8 id
    {8'h01,1'b0,8'h00}, {8'h10,1'b0,8'h00}, {8'h25,1'b0,8'h00},
    {8'h35,1'b0,8'h00}, {8'h40,1'b1,8'h55}, {8'h2A,1'b0,8'h00},
    {8'h3A,1'b0,8'h00}, {8'h40,1'b1,8'hAA},                                // R9 scratch
    {8'h07,1'b0,8'h00}, {8'h13,1'b0,8'h00}, {8'h29,1'b0,8'h00},
    {8'h3C,1'b0,8'h00}, {8'h24,1'b0,8'h00}, {8'h3B,1'b0,8'h00},
    {8'h40,1'b1,8'hB4},                                                    // R5 pairs
    {8'h00,1'b0,8'h00}, {8'h11,1'b0,8'h00},
    {8'h50,1'b1,8'h4A}, {8'h50,1'b1,8'h4B}, {8'h50,1'b1,8'h48},
    {8'h50,1'b1,8'h49}, {8'h50,1'b1,8'h4E}, {8'h50,1'b1,8'h4F},            // R7 counters
    {8'h00,1'b0,8'h00}, {8'h10,1'b0,8'h00}, {8'h21,1'b0,8'h00},
    {8'h31,1'b0,8'h00}, {8'h40,1'b1,8'hA6},                                // R8 write ignored
    {8'h0F,1'b0,8'h00}, {8'h1F,1'b0,8'h00}, {8'h50,1'b1,8'hA5},
    {8'h40,1'b1,8'hA6}                                                     // R7 wrap, R6
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_data = b; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    #1;
    cap_we = we; cap_re = re; cap_wdata = wdata; cap_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic take_rsp(output logic [7:0] v);
    @(negedge clk);
    rsp_ready = 1'b1;
    while (!rsp_valid) @(negedge clk);
    v = rsp_data;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rsp_ready = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 addr", addr, 8'h00);
    check("R12 ready", {7'b0, cmd_ready}, 8'h01);
    check("R12 rsp_valid", {7'b0, rsp_valid}, 8'h00);
    send(8'h35);
    check("R12 dlo zero / R4 wdata", cap_wdata, 8'h50);
    check("R4 we", {7'b0, cap_we}, 8'h01);
    check("R4 addr", cap_addr, 8'h00);
    send(8'h29);
    check("R3 no strobe", {6'b0, cap_we, cap_re}, 8'h00);
    // R1 / R2
    send(8'h0A); @(negedge clk); check("R1 addr lo", addr, 8'h0A);
    send(8'h1C); @(negedge clk); check("R2 addr hi", addr, 8'hCA);
    send(8'h03); @(negedge clk); check("R1 keep hi", addr, 8'hC3);

    // table walk
    for (int k = 0; k < NV; k++) begin
      send(VEC[k][16:9]);
      if (VEC[k][8]) begin
        take_rsp(got);
        check($sformatf("R6/R7/R8/R9/R5 vec %0d", k), got, VEC[k][7:0]);
      end
    end

    // R10 stall: response held back while a command waits
    send(8'h07); send(8'h13); send(8'h40);
    @(negedge clk);
    cmd_data = 8'h0F; cmd_valid = 1'b1;
    for (int c = 0; c < 5; c++) begin
      #1;
      check("R10 ready low", {7'b0, cmd_ready}, 8'h00);
      check("R10 no write", {7'b0, we}, 8'h00);
      check("R10 data held", rsp_data, 8'hB4);
      check("R10 addr held", addr, 8'h37);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    take_rsp(got);
    check("R10 rsp", got, 8'hB4);
    check("R10 ready back", {7'b0, cmd_ready}, 8'h01);

    // R11 reserved opcodes between low nibble and commit
    send(8'h2C);
    send(8'h6F); check("R11 6x strobes", {6'b0, cap_we, cap_re}, 8'h00);
    send(8'hFF); check("R11 Fx strobes", {6'b0, cap_we, cap_re}, 8'h00);
    send(8'h8A); check("R11 8x strobes", {6'b0, cap_we, cap_re}, 8'h00);
    @(negedge clk);
    check("R11 addr", addr, 8'h37);
    check("R11 no rsp", {7'b0, rsp_valid}, 8'h00);
    send(8'h3D);
    check("R11 dlo kept", cap_wdata, 8'hDC);
    check("R4 commit addr", cap_addr, 8'h37);

    // R6 plain read leaves address
    send(8'h40);
    take_rsp(got);
    check("R6 read", got, 8'hDC);
    check("R6 addr kept", addr, 8'h37);

    finish_run();
  end
endmodule